// File: doc/BRIEF.md
# Sixteen-Phase Three-Stage Input Retimer

This block brings a wide parallel input word into a fast converter clock domain through three capture registers. A fast clock runs at sixteen times the data-word rate. A free-running 4-bit phase counter divides each data period into sixteen slots. The first register, called the sample stage, captures the input on a programmable sample phase. The second register, the sync stage, copies the sample stage on a programmable sync phase. The output register always loads on the last phase of the period. Moving the two programmable phases shifts the capture instant in fine steps, so the block can absorb delays in the upstream data source.

One 8-bit configuration byte holds both phases. Its upper nibble is the sample phase and its lower nibble is the sync phase. A mode input picks how the word arrives. In wide parallel mode all 32 input bits are taken at once. In the narrow double-pumped mode only the low 16 input pins carry data, and the two halves of each word arrive at different phases of the period. A combinational flag reports a phase pair that would break the timing of the chain. While the flag is raised, the output keeps the last word it loaded.

Top module: `phase_retimer`

## Requirements
- R1: The phase counter is 0 while reset is asserted. It advances by one on every fast-clock edge after release and wraps from 15 to 0. The first edge after release therefore acts as phase 0.
- R2: With `mode_lvds`=0, the sample stage loads all 32 bits of `din` on the edge whose phase equals `phase_cfg[7:4]`.
- R3: With `mode_lvds`=1, the sample stage loads `din[15:0]` into word bits 15:0 on the edge at phase `phase_cfg[7:4]`. It loads `din[15:0]` into word bits 31:16 on the edge at phase (`phase_cfg[7:4]`+8) mod 16. `din[31:16]` has no effect on `dout` in this mode.
- R4: The sync stage copies the sample stage on the edge whose phase equals `phase_cfg[3:0]`. `dout` loads from the sync stage only on the edge at phase 15. For sample phase 0 and sync phase 7 in mode 0, a word presented before the phase-0 edge is not visible after the phase-14 edge and is visible after the phase-15 edge.
- R5: `timing_bad` is 1 whenever `phase_cfg[3:0]` is 14 or 15, in either mode.
- R6: With `mode_lvds`=0, `timing_bad` is 1 when the sample phase equals the sync phase or equals (sync phase − 1) mod 16. With `mode_lvds`=1 these two pairings do not raise the flag.
- R7: While `timing_bad` is 1, `dout` does not change, whatever `din` does. Once the flag clears, normal loading resumes.
- R8: During reset `dout` is 0, and `timing_bad` follows the configuration and mode inputs.
- R9: The settings sample 0 with sync 3 in mode 1, and sample 0 with sync 7 in mode 0, leave `timing_bad` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast | input | 1 | Fast clock, sixteen cycles per data word |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_lvds | input | 1 | 0: 32-bit parallel capture; 1: two 16-bit halves on din[15:0] |
| phase_cfg | input | 8 | [7:4] sample phase, [3:0] sync phase |
| din | input | 32 | Input data word |
| dout | output | 32 | Retimed output word |
| timing_bad | output | 1 | Illegal phase pairing for the current mode |

## Verification
Words are sent in parallel mode at the recommended phases and at a non-default phase pair. Comparing the results shows whether the capture really follows the configured phases rather than fixed slots. In the double-pumped mode the half-words are driven in windows keyed to the sample phase, with changing garbage on the unused upper pins. An output with swapped halves, a wrong half-phase offset, or leakage from the upper pins miscompares. A cycle-exact latency probe around the phase-15 edge separates a correct final stage from one that loads on another phase. Sweeping the illegal pairings, including the wrap case where the sync phase is 0 and the sample phase is 15, while pushing new words, confirms that the flag decode matches the rules and that the output freezes.

// File: rtl/retimer_pkg.sv
package retimer_pkg;
  localparam int unsigned PH_W   = 4;
  localparam int unsigned N_PH   = 1 << PH_W;
  localparam int unsigned CFG_W  = 2 * PH_W;
  localparam int unsigned LAST_PH = N_PH - 1;
  localparam int unsigned HALF_OFS = N_PH / 2;

  typedef logic [PH_W-1:0] phase_t;

  // upper field of the configuration byte: sample-stage phase
  function automatic phase_t cfg_sample(input logic [CFG_W-1:0] cfg);
    return cfg[CFG_W-1:PH_W];
  endfunction

  // lower field of the configuration byte: sync-stage phase
  function automatic phase_t cfg_sync(input logic [CFG_W-1:0] cfg);
    return cfg[PH_W-1:0];
  endfunction

  // phase offset with wrap-around
  function automatic phase_t phase_add(input phase_t p, input int unsigned d);
    return phase_t'((int'(p) + int'(d)) % int'(N_PH));
  endfunction

  // legality of a phase pairing for the selected mode
  function automatic logic phase_illegal(input logic lvds, input phase_t samp,
                                         input phase_t sync);
    logic late_sync;
    logic cmos_clash;
    late_sync  = (sync >= phase_t'(LAST_PH - 1));
    cmos_clash = (samp == sync) || (samp == phase_add(sync, LAST_PH));
    return late_sync || (!lvds && cmos_clash);
  endfunction
endpackage

// File: rtl/retimer_phase_gen.sv
module retimer_phase_gen
  import retimer_pkg::*;
#(
  parameter int unsigned PW = PH_W
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [PW-1:0] phase
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= '0;
    else        phase <= phase + 1'b1;
  end
endmodule

// File: rtl/retimer_sample_stage.sv
module retimer_sample_stage #(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lvds,
  input  logic          hit_lo,
  input  logic          hit_hi,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] q
);
  localparam int unsigned HW = DW / 2;

  for (genvar g = 0; g < 2; g++) begin : g_half
    logic [HW-1:0] src;
    logic          load;
    // narrow mode feeds both halves from the low pins, at different phases
    assign src  = lvds ? din[HW-1:0] : din[g*HW +: HW];
    if (g == 0) begin : g_lo
      assign load = hit_lo;
    end else begin : g_hi
      assign load = lvds ? hit_hi : hit_lo;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q[g*HW +: HW] <= '0;
      else if (load) q[g*HW +: HW] <= src;
    end
  end
endmodule

// File: rtl/retimer_hold_reg.sv
module retimer_hold_reg #(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [DW-1:0] d,
  output logic [DW-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (en) q <= d;
  end
endmodule

// File: rtl/phase_retimer.sv
module phase_retimer
  import retimer_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic             clk_fast,
  input  logic             rst_n,
  input  logic             mode_lvds,
  input  logic [CFG_W-1:0] phase_cfg,
  input  logic [DW-1:0]    din,
  output logic [DW-1:0]    dout,
  output logic             timing_bad
);
  phase_t        ph;
  phase_t        samp_ph;
  phase_t        sync_ph;
  logic          samp_hit;
  logic          samp_hi_hit;
  logic          sync_hit;
  logic          last_hit;
  logic          out_load;
  logic [DW-1:0] stage1;
  logic [DW-1:0] stage2;

  assign samp_ph     = cfg_sample(phase_cfg);
  assign sync_ph     = cfg_sync(phase_cfg);
  assign timing_bad  = phase_illegal(mode_lvds, samp_ph, sync_ph);

  assign samp_hit    = (ph == samp_ph);
  assign samp_hi_hit = (ph == phase_add(samp_ph, HALF_OFS));
  assign sync_hit    = (ph == sync_ph);
  assign last_hit    = (ph == phase_t'(LAST_PH));
  assign out_load    = last_hit && !timing_bad;

  retimer_phase_gen #(.PW(PH_W)) u_phase (
    .clk(clk_fast), .rst_n(rst_n), .phase(ph)
  );

  retimer_sample_stage #(.DW(DW)) u_sample (
    .clk(clk_fast), .rst_n(rst_n), .lvds(mode_lvds),
    .hit_lo(samp_hit), .hit_hi(samp_hi_hit), .din(din), .q(stage1)
  );

  retimer_hold_reg #(.DW(DW)) u_sync (
    .clk(clk_fast), .rst_n(rst_n), .en(sync_hit), .d(stage1), .q(stage2)
  );

  retimer_hold_reg #(.DW(DW)) u_final (
    .clk(clk_fast), .rst_n(rst_n), .en(out_load), .d(stage2), .q(dout)
  );
endmodule

// File: rtl/phase_retimer_chk.sv
module phase_retimer_chk
  import retimer_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mode_lvds,
  input logic [CFG_W-1:0] phase_cfg,
  input logic [PH_W-1:0]  ph,
  input logic             samp_hit,
  input logic             last_hit,
  input logic [DW-1:0]    din,
  input logic [DW-1:0]    stage1,
  input logic [DW-1:0]    dout,
  input logic             timing_bad
);
  a_r1_phase_step: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ph == PH_W'($past(ph) + 1'b1));

  a_r2_wide_capture: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(mode_lvds) && $past(samp_hit)) |-> stage1 == $past(din));

  a_r4_final_phase_only: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dout) |-> $past(last_hit));

  a_r5_late_sync: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_cfg[PH_W-1:0] >= PH_W'(LAST_PH - 1)) |-> timing_bad);

  a_r6_wide_clash: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_lvds && phase_cfg[CFG_W-1:PH_W] == phase_cfg[PH_W-1:0]) |-> timing_bad);

  a_r7_hold_on_bad: assert property (@(posedge clk) disable iff (!rst_n)
    $past(timing_bad) |-> $stable(dout));
endmodule

bind phase_retimer phase_retimer_chk #(.DW(DW)) u_chk (
  .clk(clk_fast), .rst_n(rst_n), .mode_lvds(mode_lvds), .phase_cfg(phase_cfg),
  .ph(ph), .samp_hit(samp_hit), .last_hit(last_hit), .din(din),
  .stage1(stage1), .dout(dout), .timing_bad(timing_bad)
);

// File: tb/tb_phase_retimer.sv
module tb_phase_retimer;
  localparam int CLK_PERIOD = 10;
  localparam int NPH = 16;
  localparam int WATCHDOG = 150000;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        mode_lvds = 0;
  logic [7:0]  phase_cfg = 8'h07;
  logic [31:0] din = '0;
  logic [31:0] dout;
  logic        timing_bad;

  int n_edges = 0;
  int n_checks = 0;
  int n_fail = 0;
  int m_s = 0, m_n = 7;
  logic m_lvds = 0;
  logic [31:0] last_ok = '0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  event        do_chk;

  phase_retimer dut (
    .clk_fast(clk), .rst_n(rst_n), .mode_lvds(mode_lvds), .phase_cfg(phase_cfg),
    .din(din), .dout(dout), .timing_bad(timing_bad)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) if (rst_n) n_edges <= n_edges + 1;

  function automatic logic model_bad(input logic l, input int s, input int n);
    if (n == 14 || n == 15) return 1'b1;
    if (!l && (s == n || s == (n + 15) % 16)) return 1'b1;
    return 1'b0;
  endfunction

  task automatic check(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // monitor: pops the scoreboard when the driver signals a settled window
  initial forever begin
    @(do_chk);
    while (exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(dout === e, t, dout, e);
    end
  end

  task automatic set_cfg(input logic l, input int s, input int n, input string req);
    logic eb;
    @(negedge clk);
    mode_lvds = l; phase_cfg = {4'(s), 4'(n)};
    m_lvds = l; m_s = s; m_n = n;
    #1;
    eb = model_bad(l, s, n);
    check(timing_bad === eb, req, 32'(timing_bad), 32'(eb));
  endtask

  // driver: holds one word for several data periods, then queues the expectation
  task automatic send(input logic [31:0] w, input string req);
    for (int k = 0; k < 4 * NPH; k++) begin
      int up;
      @(negedge clk);
      up = n_edges % NPH;
      if (!m_lvds) din = w;
      else begin
        din[15:0]  = (((up - m_s + NPH) % NPH) < 8) ? w[15:0] : w[31:16];
        din[31:16] = ~w[31:16] ^ 16'(up * 16'h1111) ^ 16'(k);
      end
    end
    if (!model_bad(m_lvds, m_s, m_n)) last_ok = w;
    exp_q.push_back(last_ok);
    tag_q.push_back(req);
    -> do_chk;
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * WATCHDOG);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected 0", 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(dout === 32'h0, "R8 reset dout", dout, 32'h0);
    check(timing_bad === 1'b0, "R8 reset flag", 32'(timing_bad), 32'h0);
    @(negedge clk) rst_n = 1;

    set_cfg(0, 0, 7, "R9 wide safe");
    send(32'hA5A5_1234, "R2 wide word");
    send(32'h0F0F_C3C3, "R2 wide word 2");
    set_cfg(0, 9, 2, "R6 wide legal pair");
    send(32'h1357_9BDF, "R2 R4 other phases");

    // cycle-exact latency around phase 15 (R1 R4)
    set_cfg(0, 0, 7, "R9 wide safe again");
    send(32'h1111_2222, "R4 prefill");
    while (n_edges % NPH != 0) @(negedge clk);
    din = 32'hCAFE_BEEF;
    while (n_edges % NPH != 15) @(negedge clk);
    check(dout === 32'h1111_2222, "R1 R4 before phase 15", dout, 32'h1111_2222);
    @(negedge clk);
    check(dout === 32'hCAFE_BEEF, "R1 R4 after phase 15", dout, 32'hCAFE_BEEF);
    last_ok = 32'hCAFE_BEEF;

    set_cfg(1, 0, 3, "R9 narrow safe");
    send(32'hDEAD_0001, "R3 narrow word");
    set_cfg(1, 5, 3, "R3 narrow shifted");
    send(32'h8421_7E81, "R3 narrow halves order");
    set_cfg(1, 4, 4, "R6 narrow equal ok");
    send(32'h55AA_33CC, "R6 narrow equal phases");
    set_cfg(1, 3, 4, "R6 narrow behind ok");

    set_cfg(1, 0, 14, "R5 sync 14");
    send(32'h9999_9999, "R7 hold sync 14");
    set_cfg(0, 2, 15, "R5 sync 15");
    send(32'h7777_0000, "R7 hold sync 15");
    set_cfg(0, 6, 6, "R6 wide equal");
    send(32'h6666_6666, "R7 hold wide equal");
    set_cfg(0, 5, 6, "R6 wide behind");
    set_cfg(0, 15, 0, "R6 wide wrap");
    send(32'h0BAD_F00D, "R7 hold wrap");
    set_cfg(0, 7, 6, "R6 wide ahead ok");
    send(32'h2468_ACE0, "R7 resume");

    repeat (4) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule